// File: doc/BRIEF.md
# Priority-Based Video Input Source Selector

This block decides which of two video inputs, optical or electrical, feeds the output, or whether the output is muted. It contains no video datapath. It watches three fault flags per input (lock lost, signal lost, errors seen) and drives a two-bit source code that a separate multiplexer uses. It also drives a one-cycle strobe whenever that code changes.

In manual mode, software names the source directly. In automatic mode, three programmable priority slots are walked in order and the first valid source is taken. A per-rule enable mask chooses which fault flags count. Two timers add hysteresis:
- A hold timer decides how long a fault must last before a source is dropped.
- A lock timer decides how long a dropped source must stay clean before it can be chosen again.

When a higher-priority source becomes valid again, the selector returns to it.

Top module: `src_sel_top`

## Requirements
- R1: While reset is high and on the cycle after it is released, `sel_src` is 0 (mute) and `switch_pulse` is 0.
- R2: Source codes are 0 = mute, 1 = optical and 2 = electrical. Code 3, whether given as the manual source or in a priority slot, is treated as mute.
- R3: When `auto_mode` is 0, `sel_src` takes the value of `manual_src` one clock edge after sampling, whatever the fault flags are. In this mode both validity timers are cleared and both inputs are marked valid.
- R4: When `auto_mode` is 1, `sel_src` is the source of the first priority slot, in the order first, second, third, that is valid. A mute slot is always valid. If no slot is valid, the output is mute.
- R5: An input is faulty when any enabled rule is active. `rule_mask` bit 0 enables loss of lock, bit 1 enables loss of signal and bit 2 enables the error flag. A flag whose bit is 0 has no effect.
- R6: A valid input becomes invalid only after being faulty for max(`hold_ticks`,1) consecutive sampled cycles. A fault-free cycle restarts the count.
- R7: An invalid input becomes valid again only after max(`lock_ticks`,1) consecutive fault-free sampled cycles. A faulty cycle restarts the count. The selector then returns to that input if it has higher priority.
- R8: A change in validity reaches `sel_src` one clock edge after it takes effect. A fault first sampled at edge k on the selected input, with hold H ≥ 1, changes `sel_src` at edge k+H.
- R9: `switch_pulse` is 1 for exactly the cycles in which `sel_src` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_mode | input | 1 | 1 = automatic priority selection, 0 = manual |
| manual_src | input | 2 | Source code used in manual mode |
| prio_first | input | 2 | Source code of the highest-priority slot |
| prio_second | input | 2 | Source code of the middle slot |
| prio_third | input | 2 | Source code of the lowest-priority slot |
| rule_mask | input | 3 | Enables per rule: bit0 lock, bit1 signal, bit2 errors |
| hold_ticks | input | TIMER_W | Fault cycles required before dropping an input |
| lock_ticks | input | TIMER_W | Clean cycles required before an input is valid again |
| opt_lol | input | 1 | Optical input lock lost |
| opt_los | input | 1 | Optical input signal lost |
| opt_err | input | 1 | Optical input errors detected |
| ele_lol | input | 1 | Electrical input lock lost |
| ele_los | input | 1 | Electrical input signal lost |
| ele_err | input | 1 | Electrical input errors detected |
| sel_src | output | 2 | Selected source code |
| switch_pulse | output | 1 | One-cycle strobe on every change of `sel_src` |

## Verification
Each input's validity flag and its timer are hidden state, but any error in them shows up at `sel_src`.
- A hold count that is off by one moves the switch one cycle early or late against the computed edge k+H.
- A lock counter that is not restarted produces a premature return to the higher-priority input.
- A validity flag left stale after manual mode shows up on the first automatic cycle.

A cycle-accurate reference model in the bench tracks the validity and timers of both inputs from the requirements. Any divergence is therefore reported within the same cycle as the first wrong `sel_src` or `switch_pulse`.

// File: rtl/src_sel_pkg.sv
package src_sel_pkg;

    typedef enum logic [1:0] {
        SRC_MUTE = 2'd0,
        SRC_OPT  = 2'd1,
        SRC_ELE  = 2'd2,
        SRC_RSV  = 2'd3
    } src_e;

    localparam int NUM_IN    = 2;
    localparam int NUM_SLOTS = 3;
    localparam int NUM_RULES = 3;

    localparam int RULE_LOCK = 0;
    localparam int RULE_SIG  = 1;
    localparam int RULE_ERR  = 2;

    typedef struct packed {
        logic err;
        logic los;
        logic lol;
    } flags_t;

    function automatic src_e norm_src(input logic [1:0] code);
        src_e r;
        case (code)
            2'd1:    r = SRC_OPT;
            2'd2:    r = SRC_ELE;
            default: r = SRC_MUTE;
        endcase
        return r;
    endfunction

    function automatic logic any_fault(input flags_t f, input logic [NUM_RULES-1:0] mask);
        return (f.lol & mask[RULE_LOCK]) | (f.los & mask[RULE_SIG]) | (f.err & mask[RULE_ERR]);
    endfunction

endpackage

// File: rtl/src_health.sv
module src_health
    import src_sel_pkg::*;
#(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               track_en,
    input  logic               fault,
    input  logic [TIMER_W-1:0] hold_ticks,
    input  logic [TIMER_W-1:0] lock_ticks,
    output logic               healthy
);
    localparam int EXT_W = TIMER_W + 1;

    logic [TIMER_W-1:0] run_cnt;
    logic [EXT_W-1:0]   run_next;
    logic [EXT_W-1:0]   hold_eff;
    logic [EXT_W-1:0]   lock_eff;
    logic               past_ok;

    always_comb begin
        run_next = {1'b0, run_cnt} + EXT_W'(1);
        hold_eff = (hold_ticks == '0) ? EXT_W'(1) : {1'b0, hold_ticks};
        lock_eff = (lock_ticks == '0) ? EXT_W'(1) : {1'b0, lock_ticks};
    end

    always_ff @(posedge clk) begin
        if (rst || !track_en) begin
            healthy <= 1'b1;
            run_cnt <= '0;
        end else if (healthy) begin
            if (!fault) begin
                run_cnt <= '0;
            end else if (run_next >= hold_eff) begin
                healthy <= 1'b0;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_next[TIMER_W-1:0];
            end
        end else begin
            if (fault) begin
                run_cnt <= '0;
            end else if (run_next >= lock_eff) begin
                healthy <= 1'b1;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_next[TIMER_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) past_ok <= !rst;

    AST_DROP_NEEDS_FAULT: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(healthy)) |-> $past(fault && track_en)); // R6

    AST_RECOVER_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(healthy) && $past(track_en)) |-> $past(!fault)); // R7

    AST_MANUAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!track_en)) |-> healthy); // R3

endmodule

// File: rtl/src_pick.sv
module src_pick
    import src_sel_pkg::*;
(
    input  logic [NUM_SLOTS-1:0][1:0] slot_code,
    input  logic [NUM_IN-1:0]         in_ok,
    output src_e                      pick
);
    src_e slot_src [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_ok;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_comb begin
            slot_src[s] = norm_src(slot_code[s]);
            case (slot_src[s])
                SRC_OPT: slot_ok[s] = in_ok[0];
                SRC_ELE: slot_ok[s] = in_ok[1];
                default: slot_ok[s] = 1'b1;
            endcase
        end
    end

    always_comb begin
        pick = SRC_MUTE;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (slot_ok[s]) pick = slot_src[s];
        end
    end

endmodule

// File: rtl/src_sel_top.sv
module src_sel_top
    import src_sel_pkg::*;
#(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               auto_mode,
    input  logic [1:0]         manual_src,
    input  logic [1:0]         prio_first,
    input  logic [1:0]         prio_second,
    input  logic [1:0]         prio_third,
    input  logic [2:0]         rule_mask,
    input  logic [TIMER_W-1:0] hold_ticks,
    input  logic [TIMER_W-1:0] lock_ticks,
    input  logic               opt_lol,
    input  logic               opt_los,
    input  logic               opt_err,
    input  logic               ele_lol,
    input  logic               ele_los,
    input  logic               ele_err,
    output logic [1:0]         sel_src,
    output logic               switch_pulse
);
    flags_t               in_flags [NUM_IN];
    logic [NUM_IN-1:0]    in_fault;
    logic [NUM_IN-1:0]    in_ok;
    src_e                 auto_pick;
    src_e                 sel_next;
    src_e                 sel_q;
    logic                 past_ok;

    assign in_flags[0] = '{err: opt_err, los: opt_los, lol: opt_lol};
    assign in_flags[1] = '{err: ele_err, los: ele_los, lol: ele_lol};

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        assign in_fault[i] = any_fault(in_flags[i], rule_mask);

        src_health #(.TIMER_W(TIMER_W)) health_i (
            .clk        (clk),
            .rst        (rst),
            .track_en   (auto_mode),
            .fault      (in_fault[i]),
            .hold_ticks (hold_ticks),
            .lock_ticks (lock_ticks),
            .healthy    (in_ok[i])
        );
    end

    src_pick pick_i (
        .slot_code ({prio_third, prio_second, prio_first}),
        .in_ok     (in_ok),
        .pick      (auto_pick)
    );

    assign sel_next = auto_mode ? auto_pick : norm_src(manual_src);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q        <= SRC_MUTE;
            switch_pulse <= 1'b0;
        end else begin
            sel_q        <= sel_next;
            switch_pulse <= (sel_next != sel_q);
        end
    end

    assign sel_src = sel_q;

    always_ff @(posedge clk) past_ok <= !rst;

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        sel_src != 2'd3); // R2

    AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (switch_pulse == (sel_src != $past(sel_src)))); // R9

    AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!auto_mode)) |-> (sel_src == $past(norm_src(manual_src)))); // R3

    AST_OPT_WAS_VALID: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(auto_mode) && sel_src == SRC_OPT) |-> $past(in_ok[0])); // R4

    AST_ELE_WAS_VALID: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(auto_mode) && sel_src == SRC_ELE) |-> $past(in_ok[1])); // R4

endmodule

// File: tb/src_sel_top_tb.sv
module src_sel_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 16;
    localparam int MAX_CYC = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          auto_mode = 1'b0;
    logic [1:0]    manual_src = 2'd0;
    logic [1:0]    prio_first = 2'd1, prio_second = 2'd2, prio_third = 2'd0;
    logic [2:0]    rule_mask = 3'b111;
    logic [TW-1:0] hold_ticks = 16'd4, lock_ticks = 16'd3;
    logic          opt_lol = 0, opt_los = 0, opt_err = 0;
    logic          ele_lol = 0, ele_los = 0, ele_err = 0;
    logic [1:0]    sel_src;
    logic          switch_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    src_sel_top #(.TIMER_W(TW)) dut_i (
        .clk(clk), .rst(rst), .auto_mode(auto_mode), .manual_src(manual_src),
        .prio_first(prio_first), .prio_second(prio_second), .prio_third(prio_third),
        .rule_mask(rule_mask), .hold_ticks(hold_ticks), .lock_ticks(lock_ticks),
        .opt_lol(opt_lol), .opt_los(opt_los), .opt_err(opt_err),
        .ele_lol(ele_lol), .ele_los(ele_los), .ele_err(ele_err),
        .sel_src(sel_src), .switch_pulse(switch_pulse)
    );

    // Reference model built from the requirements (codes: 0 mute, 1 opt, 2 ele, 3 -> mute)
    function automatic int f_norm(input logic [1:0] c);
        return (c == 2'd1 || c == 2'd2) ? int'(c) : 0;
    endfunction

    function automatic bit f_fault(input bit lol, input bit los, input bit err, input logic [2:0] m);
        return (lol & m[0]) | (los & m[1]) | (err & m[2]);
    endfunction

    function automatic int f_pick(input int s0, input int s1, input int s2, input bit ok0, input bit ok1);
        int sl[3];
        sl[0] = s0; sl[1] = s1; sl[2] = s2;
        for (int k = 0; k < 3; k++) begin
            if (sl[k] == 0) return 0;
            if (sl[k] == 1 && ok0) return 1;
            if (sl[k] == 2 && ok1) return 2;
        end
        return 0;
    endfunction

    int m_sel = 0;
    bit m_pulse = 0;
    bit m_h[2] = '{1, 1};
    int m_c[2] = '{0, 0};

    always @(posedge clk) begin
        int nsel;
        bit f[2];
        int he, le;
        if (rst) begin
            m_sel = 0; m_pulse = 0; m_h = '{1, 1}; m_c = '{0, 0};
        end else begin
            f[0] = f_fault(opt_lol, opt_los, opt_err, rule_mask);
            f[1] = f_fault(ele_lol, ele_los, ele_err, rule_mask);
            he = (hold_ticks == 0) ? 1 : int'(hold_ticks);
            le = (lock_ticks == 0) ? 1 : int'(lock_ticks);
            if (!auto_mode) begin
                nsel = f_norm(manual_src);
                m_h = '{1, 1}; m_c = '{0, 0};
            end else begin
                nsel = f_pick(f_norm(prio_first), f_norm(prio_second), f_norm(prio_third), m_h[0], m_h[1]);
                for (int i = 0; i < 2; i++) begin
                    if (m_h[i]) begin
                        if (!f[i]) m_c[i] = 0;
                        else if (m_c[i] + 1 >= he) begin m_h[i] = 0; m_c[i] = 0; end
                        else m_c[i] = m_c[i] + 1;
                    end else begin
                        if (f[i]) m_c[i] = 0;
                        else if (m_c[i] + 1 >= le) begin m_h[i] = 1; m_c[i] = 0; end
                        else m_c[i] = m_c[i] + 1;
                    end
                end
            end
            m_pulse = (nsel != m_sel);
            m_sel = nsel;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set_faults(input bit ol, input bit os, input bit oe, input bit el, input bit es, input bit ee);
        opt_lol = ol; opt_los = os; opt_err = oe;
        ele_lol = el; ele_los = es; ele_err = ee;
    endtask

    initial begin
        void'($urandom(32'd1234));
        tick(3);
        chk("R1 sel in reset", int'(sel_src), 0);
        chk("R1 pulse in reset", int'(switch_pulse), 0);
        rst = 1'b0;
        tick(1);
        chk("R1 sel after reset", int'(sel_src), 0);
        chk("R1 pulse after reset", int'(switch_pulse), 0);

        // Manual mode
        manual_src = 2'd1; tick(1);
        chk("R3 manual optical", int'(sel_src), 1);
        chk("R9 pulse on manual change", int'(switch_pulse), 1);
        manual_src = 2'd3; tick(1);
        chk("R2 code 3 is mute", int'(sel_src), 0);
        set_faults(1, 1, 1, 1, 1, 1);
        manual_src = 2'd2; tick(1);
        chk("R3 manual ignores faults", int'(sel_src), 2);
        tick(1);
        chk("R9 pulse single cycle", int'(switch_pulse), 0);
        set_faults(0, 0, 0, 0, 0, 0);

        // Automatic: opt, ele, mute ; hold 4 lock 3
        prio_first = 2'd1; prio_second = 2'd2; prio_third = 2'd0;
        hold_ticks = 16'd4; lock_ticks = 16'd3; rule_mask = 3'b111;
        auto_mode = 1'b1; tick(1);
        chk("R4 first slot chosen", int'(sel_src), 1);

        opt_los = 1; tick(4);
        chk("R6 held before hold time", int'(sel_src), 1);
        tick(1);
        chk("R8 switch at edge k+H", int'(sel_src), 2);
        chk("R9 pulse on auto switch", int'(switch_pulse), 1);
        tick(1);
        chk("R9 pulse drops", int'(switch_pulse), 0);

        opt_los = 0; tick(3);
        chk("R7 no return before lock", int'(sel_src), 2);
        tick(1);
        chk("R7 return to higher priority", int'(sel_src), 1);

        opt_lol = 1; tick(3); opt_lol = 0; tick(1); opt_lol = 1; tick(3);
        chk("R6 interrupted fault restarts", int'(sel_src), 1);
        opt_lol = 0; tick(1);

        rule_mask = 3'b011; opt_err = 1; tick(10);
        chk("R5 masked error ignored", int'(sel_src), 1);
        rule_mask = 3'b111; tick(4);
        chk("R5 enabled error counted (before hold)", int'(sel_src), 1);
        tick(1);
        chk("R5 enabled error drops input", int'(sel_src), 2);
        opt_err = 0; tick(4);
        chk("R7 return after error clears", int'(sel_src), 1);

        prio_second = 2'd2; prio_third = 2'd2;
        opt_los = 1; ele_los = 1; tick(5);
        chk("R4 nothing valid gives mute", int'(sel_src), 0);
        prio_first = 2'd0; set_faults(0, 0, 0, 0, 0, 0); tick(1);
        chk("R4 mute slot first", int'(sel_src), 0);
        prio_first = 2'd3; tick(6);
        chk("R2 slot code 3 as mute", int'(sel_src), 0);

        auto_mode = 0; manual_src = 2'd1; opt_los = 1; tick(1);
        auto_mode = 1; prio_first = 2'd1; prio_second = 2'd2; prio_third = 2'd0; tick(1);
        chk("R3 timers cleared by manual", int'(sel_src), 1);
        tick(3);
        chk("R3 fresh hold count", int'(sel_src), 1);
        tick(1);
        chk("R8 fresh hold switch", int'(sel_src), 2);

        hold_ticks = 16'd0; lock_ticks = 16'd0; opt_los = 0; tick(2);
        chk("R7 lock zero acts as one", int'(sel_src), 1);
        opt_los = 1; tick(1);
        chk("R6 hold zero not immediate", int'(sel_src), 1);
        tick(1);
        chk("R6 hold zero acts as one", int'(sel_src), 2);

        // Random phase against the reference model
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc % 40 == 0) begin
                hold_ticks = 16'($urandom_range(0, 6));
                lock_ticks = 16'($urandom_range(0, 6));
                rule_mask  = 3'($urandom_range(0, 7));
                prio_first = 2'($urandom_range(0, 3));
                prio_second = 2'($urandom_range(0, 3));
                prio_third = 2'($urandom_range(0, 3));
                manual_src = 2'($urandom_range(0, 3));
                auto_mode  = ($urandom_range(0, 7) != 0);
            end
            if ($urandom_range(0, 7) == 0) opt_lol = ~opt_lol;
            if ($urandom_range(0, 7) == 0) opt_los = ~opt_los;
            if ($urandom_range(0, 9) == 0) opt_err = ~opt_err;
            if ($urandom_range(0, 7) == 0) ele_lol = ~ele_lol;
            if ($urandom_range(0, 7) == 0) ele_los = ~ele_los;
            if ($urandom_range(0, 9) == 0) ele_err = ~ele_err;
            tick(1);
            chk("R4 R5 R6 R7 model sel", int'(sel_src), m_sel);
            chk("R9 model pulse", int'(switch_pulse), int'(m_pulse));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * MAX_CYC);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule